// File: doc/BRIEF.md
# Ordered Trigger Sequencer

This block watches single-cycle match pulses from three address/data comparator channels (numbered 3, 2 and 1) and from a separate reset-point channel. It turns them into a debug action when the matches arrive in a programmed order. The comparators themselves sit outside the block. The sequencer only decides whether the pulses it receives complete the programmed ordering, how many times that ordering has completed, and which action to raise.

Two orderings are supported: channel 3, then 2, then 1; or channel 2, then 1. Only the match on the last channel of the ordering completes it. A repeat target delays the action until the ordering has completed that many times. The action is either a break request or a trace-stop request, and is emitted as a one-cycle pulse on its own output.

When the reset point is enabled, a reset-point match rewinds the ordering to its start. A power-on-reset indication masks every match in the cycle where it is present. While software rewrites the configuration it raises an update strobe, which freezes matching and clears all progress.

Top module: `ordered_trigger`

## Requirements
- R1: After `rstN` is released, both action outputs are low, the sequence is at its start and the completion count is zero.
- R2: With `cfgMode` = 1, the ordering completes only when matches arrive as channel 3, then channel 2, then channel 1. The action pulse is high for exactly one cycle, in the cycle after the clock edge that samples the completing channel-1 match.
- R3: With `cfgMode` = 2, the ordering completes on a channel-2 match followed later by a channel-1 match. Channel 3 is ignored in this mode.
- R4: A match on a channel that is not the next one expected leaves the progress unchanged and does not rewind it. For example, 3,1,2,3,1 in mode 1 completes only on the final 1.
- R5: `cfgAction` = 0 selects `breakPulse` and `cfgAction` = 1 selects `traceStopPulse`. The unselected output stays low, and the two outputs are never high together.
- R6: With `cfgRpEn` = 1, a `matchRp` pulse returns the sequence to its start and takes priority over any channel match in the same cycle. For example, 3,2,rp,1 does not complete, while 3,2,rp,3,2,1 does. The completion count is kept. With `cfgRpEn` = 0, `matchRp` has no effect.
- R7: The action fires on the completion that brings the number of completions to `cfgRepeat`. A `cfgRepeat` of 0 is treated as 1.
- R8: In a cycle with `porFlag` high, every match input, including `matchRp`, is ignored.
- R9: In a cycle with `cfgWrite` high, the sequence returns to its start, the completion count is cleared, no match is taken and no action fires.
- R10: `cfgMode` = 0 or 3 disables the sequencer: no action fires, and progress and the completion count are held clear.
- R11: After the action fires, the sequence and the completion count return to their initial values, so the next action again needs `cfgRepeat` full completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| matchC3 | input | 1 | Channel 3 match pulse |
| matchC2 | input | 1 | Channel 2 match pulse |
| matchC1 | input | 1 | Channel 1 match pulse (final channel) |
| matchRp | input | 1 | Reset-point channel match pulse |
| porFlag | input | 1 | Power-on reset indication; masks matches this cycle |
| cfgWrite | input | 1 | Configuration update in progress |
| cfgMode | input | 2 | 0 off, 1 order 3-2-1, 2 order 2-1, 3 off |
| cfgAction | input | 1 | 0 break, 1 trace stop |
| cfgRpEn | input | 1 | Reset-point enable |
| cfgRepeat | input | CNT_W | Completions needed per action (0 means 1) |
| breakPulse | output | 1 | One-cycle break request |
| traceStopPulse | output | 1 | One-cycle trace-stop request |

## Verification
The bound checker examines every cycle. It confirms that no action follows a cycle carrying a configuration update, a power-on-reset flag, an enabled reset-point match or a disabled mode. It also confirms that every action is preceded by a channel-1 match, that the action lands on the output chosen by the action setting, and that the stage register never takes its unused code. The properties cannot reach ordering, the refusal to rewind on out-of-order matches, repeat counting, or the clearing of the count after firing, because these depend on history longer than a property window. The bench shows them through directed scenarios and a sweep over every mode, action, reset-point setting and small repeat value, with pseudo-random match traffic checked cycle by cycle against an arithmetic model.

// File: rtl/ordtrig_pkg.sv
`timescale 1ns/1ps
package ordtrig_pkg;

  typedef enum logic [1:0] {
    SEQ_OFF  = 2'd0,
    SEQ_321  = 2'd1,
    SEQ_21   = 2'd2,
    SEQ_RSVD = 2'd3
  } seqMode_e;

  // Binary stage: which channels of the ordering have already been seen.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HAVE3 = 2'd1,
    ST_HAVE2 = 2'd2,
    ST_UNUSED = 2'd3
  } stage_e;

  // Strobes from the control FSM to the counting/output datapath.
  typedef struct packed {
    logic clrCount;
    logic incCount;
    logic fire;
  } seqStrobe_t;

  localparam int NUM_ACT = 2;

endpackage

// File: rtl/ordtrig_ctrl.sv
`timescale 1ns/1ps
module ordtrig_ctrl
  import ordtrig_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       matchC3,
  input  logic       matchC2,
  input  logic       matchC1,
  input  logic       matchRp,
  input  logic       porFlag,
  input  logic       cfgWrite,
  input  logic [1:0] cfgMode,
  input  logic       cfgRpEn,
  input  logic       countHit,
  output seqStrobe_t strobe,
  output stage_e     stageQ
);

  stage_e stageD;
  logic   modeOn;
  logic   takeMatch;

  assign modeOn    = (cfgMode == SEQ_321) || (cfgMode == SEQ_21);
  assign takeMatch = modeOn && !cfgWrite && !porFlag;

  always_comb begin
    stageD = stageQ;
    strobe = '0;
    if (cfgWrite || !modeOn) begin
      stageD          = ST_IDLE;
      strobe.clrCount = 1'b1;
    end else if (takeMatch) begin
      if (cfgRpEn && matchRp) begin
        stageD = ST_IDLE;
      end else begin
        unique case (stageQ)
          ST_IDLE: begin
            if (cfgMode == SEQ_321 && matchC3)     stageD = ST_HAVE3;
            else if (cfgMode == SEQ_21 && matchC2) stageD = ST_HAVE2;
          end
          ST_HAVE3: begin
            if (matchC2) stageD = ST_HAVE2;
          end
          ST_HAVE2: begin
            if (matchC1) begin
              stageD = ST_IDLE;
              if (countHit) begin
                strobe.fire     = 1'b1;
                strobe.clrCount = 1'b1;
              end else begin
                strobe.incCount = 1'b1;
              end
            end
          end
          default: stageD = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ <= ST_IDLE;
    else       stageQ <= stageD;
  end

endmodule

// File: rtl/ordtrig_dp.sv
`timescale 1ns/1ps
module ordtrig_dp
  import ordtrig_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [CNT_W-1:0] cfgRepeat,
  input  logic             cfgAction,
  output logic             countHit,
  output logic             breakPulse,
  output logic             traceStopPulse
);

  localparam int WIDE_W = CNT_W + 1;

  logic [CNT_W-1:0]  countQ;
  logic [WIDE_W-1:0] countNext;
  logic [WIDE_W-1:0] target;
  logic [NUM_ACT-1:0] actQ;

  assign countNext = {1'b0, countQ} + WIDE_W'(1);
  assign target    = (cfgRepeat == '0) ? WIDE_W'(1) : {1'b0, cfgRepeat};
  assign countHit  = (countNext >= target);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                countQ <= '0;
    else if (strobe.clrCount) countQ <= '0;
    else if (strobe.incCount) countQ <= countNext[CNT_W-1:0];
  end

  for (genvar a = 0; a < NUM_ACT; a++) begin : g_act
    localparam logic ACT_CODE = 1'(a);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) actQ[a] <= 1'b0;
      else       actQ[a] <= strobe.fire && (cfgAction == ACT_CODE);
    end
  end

  assign breakPulse     = actQ[0];
  assign traceStopPulse = actQ[1];

endmodule

// File: rtl/ordered_trigger.sv
`timescale 1ns/1ps
module ordered_trigger
  import ordtrig_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             matchC3,
  input  logic             matchC2,
  input  logic             matchC1,
  input  logic             matchRp,
  input  logic             porFlag,
  input  logic             cfgWrite,
  input  logic [1:0]       cfgMode,
  input  logic             cfgAction,
  input  logic             cfgRpEn,
  input  logic [CNT_W-1:0] cfgRepeat,
  output logic             breakPulse,
  output logic             traceStopPulse
);

  seqStrobe_t strobe;
  stage_e     stageQ;
  logic       countHit;

  ordtrig_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .matchC3  (matchC3),
    .matchC2  (matchC2),
    .matchC1  (matchC1),
    .matchRp  (matchRp),
    .porFlag  (porFlag),
    .cfgWrite (cfgWrite),
    .cfgMode  (cfgMode),
    .cfgRpEn  (cfgRpEn),
    .countHit (countHit),
    .strobe   (strobe),
    .stageQ   (stageQ)
  );

  ordtrig_dp #(.CNT_W(CNT_W)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .cfgRepeat      (cfgRepeat),
    .cfgAction      (cfgAction),
    .countHit       (countHit),
    .breakPulse     (breakPulse),
    .traceStopPulse (traceStopPulse)
  );

endmodule

// File: rtl/ordered_trigger_chk.sv
`timescale 1ns/1ps
module ordered_trigger_chk (
  input logic       clk,
  input logic       rstN,
  input logic       matchC1,
  input logic       matchRp,
  input logic       porFlag,
  input logic       cfgWrite,
  input logic [1:0] cfgMode,
  input logic       cfgAction,
  input logic       cfgRpEn,
  input logic [1:0] stageQ,
  input logic       breakPulse,
  input logic       traceStopPulse
);

  logic anyAct;
  assign anyAct = breakPulse || traceStopPulse;

  p_stage_legal_r1: assert property (@(posedge clk) disable iff (!rstN)
    stageQ != 2'd3);

  p_fire_after_last_r2: assert property (@(posedge clk) disable iff (!rstN)
    anyAct |-> $past(matchC1));

  p_break_sel_r5: assert property (@(posedge clk) disable iff (!rstN)
    breakPulse |-> $past(cfgAction == 1'b0));

  p_trace_sel_r5: assert property (@(posedge clk) disable iff (!rstN)
    traceStopPulse |-> $past(cfgAction == 1'b1));

  p_one_action_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({breakPulse, traceStopPulse}));

  p_rp_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRpEn && matchRp) |=> !anyAct);

  p_por_masks_r8: assert property (@(posedge clk) disable iff (!rstN)
    porFlag |=> !anyAct);

  p_cfg_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> !anyAct);

  p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'd0 || cfgMode == 2'd3) |=> !anyAct);

endmodule

bind ordered_trigger ordered_trigger_chk u_chk (.*);

// File: tb/sim_ordered_trigger.sv
`timescale 1ns/1ps
module sim_ordered_trigger;

  localparam int CNT_W = 4;
  localparam logic [3:0] E0 = 4'b0000, E3 = 4'b1000, E2 = 4'b0100,
                         E1 = 4'b0010, ERP = 4'b0001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic matchC3 = 0, matchC2 = 0, matchC1 = 0, matchRp = 0;
  logic porFlag = 0, cfgWrite = 0, cfgAction = 0, cfgRpEn = 0;
  logic [1:0] cfgMode = 2'd0;
  logic [CNT_W-1:0] cfgRepeat = '0;
  logic breakPulse, traceStopPulse;

  int errs = 0;
  int checks = 0;
  logic [1:0] obs;
  logic [1:0] mExp;
  int mStage = 0;
  int mCount = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  ordered_trigger #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .matchC3(matchC3), .matchC2(matchC2),
    .matchC1(matchC1), .matchRp(matchRp), .porFlag(porFlag),
    .cfgWrite(cfgWrite), .cfgMode(cfgMode), .cfgAction(cfgAction),
    .cfgRpEn(cfgRpEn), .cfgRepeat(cfgRepeat),
    .breakPulse(breakPulse), .traceStopPulse(traceStopPulse)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: {break,traceStop} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Model of the requirements: updates on each sampled cycle.
  task automatic model(input logic [3:0] ev, input logic por, input logic cw);
    int tgt;
    mExp = 2'b00;
    if (cw || !(cfgMode == 2'd1 || cfgMode == 2'd2)) begin
      mStage = 0; mCount = 0;
    end else if (!por) begin
      if (cfgRpEn && ev[0]) mStage = 0;
      else if (mStage == 0) begin
        if (cfgMode == 2'd1 && ev[3]) mStage = 1;
        else if (cfgMode == 2'd2 && ev[2]) mStage = 2;
      end else if (mStage == 1) begin
        if (ev[2]) mStage = 2;
      end else if (ev[1]) begin
        mStage = 0;
        tgt = (cfgRepeat == 0) ? 1 : int'(cfgRepeat);
        if (mCount + 1 >= tgt) begin
          mCount = 0;
          mExp = cfgAction ? 2'b01 : 2'b10;
        end else mCount++;
      end
    end
  endtask

  task automatic step(input logic [3:0] ev, input logic por, input logic cw);
    @(negedge clk);
    {matchC3, matchC2, matchC1, matchRp} = ev;
    porFlag = por;
    cfgWrite = cw;
    @(posedge clk);
    #1;
    obs = {breakPulse, traceStopPulse};
    model(ev, por, cw);
  endtask

  task automatic ev1(input logic [3:0] ev);
    step(ev, 1'b0, 1'b0);
  endtask

  task automatic setCfg(input logic [1:0] m, input logic a, input logic rp, input int rep);
    @(negedge clk);
    cfgMode = m; cfgAction = a; cfgRpEn = rp; cfgRepeat = CNT_W'(rep);
    step(E0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 outputs in reset", {breakPulse, traceStopPulse}, 2'b00);
    @(negedge clk); rstN = 1'b1;
    ev1(E0);
    check("R1 outputs after reset", obs, 2'b00);

    // R2: order 3,2,1 with break
    setCfg(2'd1, 1'b0, 1'b0, 0);
    ev1(E3); check("R2 after 3", obs, 2'b00);
    ev1(E2); check("R2 after 2", obs, 2'b00);
    ev1(E1); check("R2 fire on 1", obs, 2'b10);
    ev1(E0); check("R2 pulse one cycle", obs, 2'b00);
    ev1(E1); check("R2 lone 1 ignored", obs, 2'b00);

    // R3: order 2,1; channel 3 ignored
    setCfg(2'd2, 1'b0, 1'b0, 0);
    ev1(E3); ev1(E1); check("R3 3 then 1 no fire", obs, 2'b00);
    ev1(E2); ev1(E1); check("R3 fire on 2,1", obs, 2'b10);

    // R4: out-of-order matches neither advance nor rewind
    setCfg(2'd1, 1'b0, 1'b0, 0);
    ev1(E3); ev1(E1); check("R4 1 skipped ahead", obs, 2'b00);
    ev1(E2); ev1(E3); check("R4 3 again no rewind", obs, 2'b00);
    ev1(E1); check("R4 fire on final 1", obs, 2'b10);

    // R5: trace-stop action
    setCfg(2'd2, 1'b1, 1'b0, 0);
    ev1(E2); ev1(E1); check("R5 trace stop selected", obs, 2'b01);

    // R6: reset point
    setCfg(2'd1, 1'b0, 1'b1, 0);
    ev1(E3); ev1(E2); ev1(ERP); ev1(E1); check("R6 3,2,rp,1 no fire", obs, 2'b00);
    ev1(E3); ev1(E2); ev1(E1); check("R6 3,2,1 after rp fires", obs, 2'b10);
    ev1(E3); ev1(E2); ev1(E1 | ERP); check("R6 rp beats same-cycle 1", obs, 2'b00);
    setCfg(2'd1, 1'b0, 1'b0, 0);
    ev1(E3); ev1(E2); ev1(ERP); ev1(E1); check("R6 rp disabled ignored", obs, 2'b10);

    // R6 count kept across rp, R7 repeat count, R11 clear after fire
    setCfg(2'd2, 1'b0, 1'b1, 3);
    ev1(E2); ev1(E1); check("R7 1st of 3", obs, 2'b00);
    ev1(E2); ev1(ERP); ev1(E1); check("R6 rp keeps count", obs, 2'b00);
    ev1(E2); ev1(E1); check("R7 2nd of 3", obs, 2'b00);
    ev1(E2); ev1(E1); check("R7 3rd of 3 fires", obs, 2'b10);
    ev1(E2); ev1(E1); check("R11 count cleared 1", obs, 2'b00);
    ev1(E2); ev1(E1); check("R11 count cleared 2", obs, 2'b00);
    ev1(E2); ev1(E1); check("R11 fires after 3 more", obs, 2'b10);

    // R8: power-on reset masks matches
    setCfg(2'd2, 1'b0, 1'b1, 0);
    step(E2, 1'b1, 1'b0); ev1(E1); check("R8 2 masked by por", obs, 2'b00);
    ev1(E2); step(E1, 1'b1, 1'b0); check("R8 1 masked by por", obs, 2'b00);
    ev1(E1); check("R8 progress held", obs, 2'b10);
    ev1(E2); step(ERP, 1'b1, 1'b0); ev1(E1); check("R8 rp masked by por", obs, 2'b10);

    // R9: configuration update clears progress
    setCfg(2'd2, 1'b0, 1'b0, 0);
    ev1(E2); step(E1, 1'b0, 1'b1); check("R9 match during update", obs, 2'b00);
    ev1(E1); check("R9 progress cleared", obs, 2'b00);
    setCfg(2'd2, 1'b0, 1'b0, 2);
    ev1(E2); ev1(E1); step(E0, 1'b0, 1'b1);
    ev1(E2); ev1(E1); check("R9 count cleared", obs, 2'b00);

    // R10: disabled modes
    setCfg(2'd0, 1'b0, 1'b0, 0);
    ev1(E3); ev1(E2); ev1(E1); check("R10 mode 0 silent", obs, 2'b00);
    setCfg(2'd3, 1'b0, 1'b0, 0);
    ev1(E2); ev1(E1); check("R10 mode 3 silent", obs, 2'b00);

    // Sweep: all modes, actions, rp settings, repeat 0..3 against model
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 2; a++)
        for (int r = 0; r < 2; r++)
          for (int rep = 0; rep < 4; rep++) begin
            setCfg(2'(m), 1'(a), 1'(r), rep);
            check("R9 sweep update cycle", obs, 2'b00);
            for (int c = 0; c < 60; c++) begin
              lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
              step({lfsr[3:1], lfsr[0] & lfsr[5]}, lfsr[9:6] == 4'd0,
                   lfsr[14:10] == 5'd0);
              check("R2/R3 R4 R6 R7 R8 R11 sweep", obs, mExp);
            end
          end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule